// File: doc/BRIEF.md
# Power and Boot Sequencing Controller

This block brings a plug-in FPGA module up and takes it down in a safe order. When a power-on request arrives, it latches the boot-mode setting and turns on the module's supplies. It then waits for power-good. Next it drives the latched boot mode onto the module's pins while the module is still held in cold reset. After that it releases reset and waits for the module to report that configuration is done. Two internal timeouts supervise the waits: a short one for power-good and a long one for configuration-done.

The status lines from the module arrive asynchronously. Each passes through a synchronizer and an edge detector. The resulting edges are arbitrated so that the sequencer handles only one event per cycle. If a supply collapses, configuration is lost or a timeout expires, the module is forced into reset with power removed, and a fault flag is latched. Only a power-off request clears that fault. A power-off request in a powered state asserts reset one cycle before it removes power.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pwr_en`, `por_n`, `boot_mode`, `ready` and `fault` are all 0.
- R2: In idle, an `on_req` pulse latches `mode_cfg` and raises `pwr_en` with `por_n` held low. Values applied to `mode_cfg` after that pulse have no effect on `boot_mode`.
- R3: A rising edge on `pgood_in` is seen two cycles after it is applied. The cycle after it is seen, `boot_mode` takes the latched value while `por_n` stays low. One cycle later `por_n` goes high and the long timeout of `LONG_CYC` cycles starts.
- R4: `boot_mode` changes only while `pwr_en` is 1 and `por_n` is 0, in both the cycle before the change and the cycle of the change.
- R5: A rising edge on `done_in` within the long timeout sets `ready`, with `pwr_en` and `por_n` both high.
- R6: If power-good is not seen within `SHORT_CYC` cycles of power-on, `pwr_en` stays high for exactly `SHORT_CYC` cycles. It then drops, `por_n` stays low and `fault` is set.
- R7: If configuration-done is not seen within `LONG_CYC` cycles of reset release, `pwr_en` and `por_n` drop and `fault` is set.
- R8: A falling edge on `pgood_in` after reset release, or on `done_in` while `ready`, drops `pwr_en` and `por_n` in the same cycle and sets `fault`.
- R9: `fault` is held, and `on_req` is ignored, until an `off_req` pulse returns the block to idle with `fault` cleared.
- R10: An `off_req` pulse in a powered state first drives `por_n` low for one cycle while `pwr_en` is still 1. It then drops `pwr_en` and returns to idle.
- R11: Only one event is handled per cycle. A timeout expiry in the same cycle as an awaited rising edge wins and leads to fault.
- R12: An `on_req` pulse outside idle has no effect, so a running module stays `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Power-on request pulse |
| off_req | input | 1 | Power-off request pulse |
| mode_cfg | input | MODE_W | Boot-mode setting, sampled on power-on |
| pgood_in | input | 1 | Module power-good, asynchronous |
| done_in | input | 1 | Module configuration-done, asynchronous |
| pwr_en | output | 1 | Module supply enable, high = on |
| por_n | output | 1 | Module cold reset/load, low = held in reset |
| boot_mode | output | MODE_W | Boot-mode pins driven to the module |
| ready | output | 1 | Module configured and running |
| fault | output | 1 | Latched sequencing fault |

## Verification
The bench builds the block with `SHORT_CYC` = 8 and `LONG_CYC` = 20. With these values both timeouts expire within a few dozen cycles, so each run can place a status edge on every cycle near a timeout boundary. That includes the last cycle that still succeeds and the first one that loses to the expiry. The two-stage synchronizer latency is then measured against each of these windows.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR_WAIT,
    ST_BOOT_SET,
    ST_CFG_WAIT,
    ST_RUN,
    ST_DROP,
    ST_FAULT
  } seq_state_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_PG_FALL,
    EV_DN_FALL,
    EV_EXPIRE,
    EV_PG_RISE,
    EV_DN_RISE
  } seq_event_e;

  typedef enum logic [1:0] {
    TMR_HOLD,
    TMR_SHORT,
    TMR_LONG,
    TMR_STOP
  } tmr_cmd_e;

  localparam int NUM_STAT = 2;
  localparam int IDX_PG   = 0;
  localparam int IDX_DN   = 1;

endpackage

// File: rtl/pwrseq_edge_sync.sv
module pwrseq_edge_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  localparam int TAPS = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [TAPS-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[TAPS-2:0], din[g]};
      end
    end

    assign rise[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
  end

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
  import pwrseq_pkg::*;
#(
  parameter int SHORT_CYC = 100_000,
  parameter int LONG_CYC  = 25_000_000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  tmr_cmd_e cmd,
  output logic     expire
);

  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          tick_en;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    unique case (cmd)
      TMR_SHORT: begin cnt_d = SHORT_LD; act_d = 1'b1; end
      TMR_LONG:  begin cnt_d = LONG_LD;  act_d = 1'b1; end
      TMR_STOP:  begin act_d = 1'b0; end
      default: begin
        if (act_q) begin
          if (cnt_q == '0) act_d = 1'b0;
          else             cnt_d = cnt_q - 1'b1;
        end
      end
    endcase
  end

  assign tick_en = act_q || (cmd != TMR_HOLD);
  assign expire  = act_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (tick_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                on_req,
  input  logic                off_req,
  input  logic [MODE_W-1:0]   mode_cfg,
  input  logic [NUM_STAT-1:0] rise,
  input  logic [NUM_STAT-1:0] fall,
  input  logic                expire,
  output tmr_cmd_e            tmr_cmd,
  output logic                pwr_en,
  output logic                por_n,
  output logic [MODE_W-1:0]   boot_mode,
  output logic                ready,
  output logic                fault
);

  seq_state_e        state_q, state_d;
  seq_event_e        ev;
  logic [MODE_W-1:0] mode_lat_q;
  logic [MODE_W-1:0] boot_q;
  logic              mode_ld;
  logic              boot_ld;

  // one event per cycle, losses first
  always_comb begin
    if      (fall[IDX_PG]) ev = EV_PG_FALL;
    else if (fall[IDX_DN]) ev = EV_DN_FALL;
    else if (expire)       ev = EV_EXPIRE;
    else if (rise[IDX_PG]) ev = EV_PG_RISE;
    else if (rise[IDX_DN]) ev = EV_DN_RISE;
    else                   ev = EV_NONE;
  end

  always_comb begin
    state_d = state_q;
    tmr_cmd = TMR_HOLD;
    mode_ld = 1'b0;
    boot_ld = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (on_req) begin
          state_d = ST_PWR_WAIT;
          tmr_cmd = TMR_SHORT;
          mode_ld = 1'b1;
        end
      end
      ST_PWR_WAIT: begin
        if (ev == EV_EXPIRE) begin
          state_d = ST_FAULT;
        end else if (ev == EV_PG_RISE) begin
          state_d = ST_BOOT_SET;
          tmr_cmd = TMR_STOP;
          boot_ld = 1'b1;
        end
      end
      ST_BOOT_SET: begin
        if (ev == EV_PG_FALL) begin
          state_d = ST_FAULT;
        end else begin
          state_d = ST_CFG_WAIT;
          tmr_cmd = TMR_LONG;
        end
      end
      ST_CFG_WAIT: begin
        if (ev == EV_PG_FALL || ev == EV_EXPIRE) begin
          state_d = ST_FAULT;
          tmr_cmd = TMR_STOP;
        end else if (ev == EV_DN_RISE) begin
          state_d = ST_RUN;
          tmr_cmd = TMR_STOP;
        end
      end
      ST_RUN: begin
        if (ev == EV_PG_FALL || ev == EV_DN_FALL) state_d = ST_FAULT;
      end
      ST_DROP:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_FAULT;
      default:  state_d = ST_IDLE;
    endcase

    if (off_req) begin
      mode_ld = 1'b0;
      boot_ld = 1'b0;
      tmr_cmd = TMR_STOP;
      if (state_q == ST_IDLE || state_q == ST_FAULT || state_q == ST_DROP)
        state_d = ST_IDLE;
      else
        state_d = ST_DROP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lat_q <= '0;
    end else if (mode_ld) begin
      mode_lat_q <= mode_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= '0;
    end else if (boot_ld) begin
      boot_q <= mode_lat_q;
    end
  end

  assign pwr_en    = (state_q == ST_PWR_WAIT) || (state_q == ST_BOOT_SET) ||
                     (state_q == ST_CFG_WAIT) || (state_q == ST_RUN) ||
                     (state_q == ST_DROP);
  assign por_n     = (state_q == ST_CFG_WAIT) || (state_q == ST_RUN);
  assign ready     = (state_q == ST_RUN);
  assign fault     = (state_q == ST_FAULT);
  assign boot_mode = boot_q;

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int SHORT_CYC   = 100_000,
  parameter int LONG_CYC    = 25_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_req,
  input  logic              off_req,
  input  logic [MODE_W-1:0] mode_cfg,
  input  logic              pgood_in,
  input  logic              done_in,
  output logic              pwr_en,
  output logic              por_n,
  output logic [MODE_W-1:0] boot_mode,
  output logic              ready,
  output logic              fault
);

  logic [NUM_STAT-1:0] stat_raw;
  logic [NUM_STAT-1:0] stat_rise;
  logic [NUM_STAT-1:0] stat_fall;
  logic                tmr_expire;
  tmr_cmd_e            tmr_cmd;

  assign stat_raw[IDX_PG] = pgood_in;
  assign stat_raw[IDX_DN] = done_in;

  pwrseq_edge_sync #(
    .N      (NUM_STAT),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (stat_raw),
    .rise  (stat_rise),
    .fall  (stat_fall)
  );

  pwrseq_timer #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (tmr_cmd),
    .expire (tmr_expire)
  );

  pwrseq_fsm #(
    .MODE_W (MODE_W)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_req    (on_req),
    .off_req   (off_req),
    .mode_cfg  (mode_cfg),
    .rise      (stat_rise),
    .fall      (stat_fall),
    .expire    (tmr_expire),
    .tmr_cmd   (tmr_cmd),
    .pwr_en    (pwr_en),
    .por_n     (por_n),
    .boot_mode (boot_mode),
    .ready     (ready),
    .fault     (fault)
  );

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              off_req,
  input logic              pwr_en,
  input logic              por_n,
  input logic [MODE_W-1:0] boot_mode,
  input logic              ready,
  input logic              fault
);

  // R4
  boot_mode_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(boot_mode) |-> (pwr_en && !por_n && $past(pwr_en) && !$past(por_n)));

  // R3
  release_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_n |-> pwr_en);

  // R5
  ready_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (pwr_en && por_n && !fault));

  // R8
  fault_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!pwr_en && !por_n));

  // R9
  fault_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !off_req) |=> fault);

  // R10
  reset_before_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(por_n) && !fault) |-> pwr_en);

endmodule

bind pwrseq_ctrl pwrseq_chk #(.MODE_W(MODE_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .off_req   (off_req),
  .pwr_en    (pwr_en),
  .por_n     (por_n),
  .boot_mode (boot_mode),
  .ready     (ready),
  .fault     (fault)
);

// File: tb/test_pwrseq_ctrl.sv
module test_pwrseq_ctrl;

  localparam int SHORT_CYC = 8;
  localparam int LONG_CYC  = 20;
  localparam int OBS_CYC   = 60;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] pg_at;
    logic [7:0] dn_at;
    logic       ex_ready;
    logic       ex_fault;
    logic [1:0] ex_mode;
  } vec_t;

  localparam logic [7:0] NEVER = 8'd255;
  localparam int NVEC = 7;
  // pg_at / dn_at: cycle after power-on at which the input is raised
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 8'd0,  8'd3,  1'b1, 1'b0, 2'd1},  // R5 normal
    '{2'd2, 8'd4,  8'd20, 1'b1, 1'b0, 2'd2},  // R3 last good power-good cycle
    '{2'd3, 8'd5,  NEVER, 1'b0, 1'b1, 2'd0},  // R11 expiry wins same cycle
    '{2'd3, NEVER, NEVER, 1'b0, 1'b1, 2'd0},  // R6 no power-good
    '{2'd2, 8'd2,  NEVER, 1'b0, 1'b1, 2'd2},  // R7 no done
    '{2'd1, 8'd1,  8'd21, 1'b1, 1'b0, 2'd1},  // R5 last good done cycle
    '{2'd1, 8'd1,  8'd22, 1'b0, 1'b1, 2'd1}   // R11 done loses to expiry
  };

  logic       clk;
  logic       rst_n;
  logic       on_req;
  logic       off_req;
  logic [1:0] mode_cfg;
  logic       pgood_in;
  logic       done_in;
  logic       pwr_en;
  logic       por_n;
  logic [1:0] boot_mode;
  logic       ready;
  logic       fault;

  int n_chk;
  int n_fail;
  logic [1:0] bm_prev;

  pwrseq_ctrl #(
    .SHORT_CYC   (SHORT_CYC),
    .LONG_CYC    (LONG_CYC),
    .SYNC_STAGES (2),
    .MODE_W      (2)
  ) i_pwrseq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .on_req    (on_req),
    .off_req   (off_req),
    .mode_cfg  (mode_cfg),
    .pgood_in  (pgood_in),
    .done_in   (done_in),
    .pwr_en    (pwr_en),
    .por_n     (por_n),
    .boot_mode (boot_mode),
    .ready     (ready),
    .fault     (fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    on_req   = 1'b0;
    off_req  = 1'b0;
    pgood_in = 1'b0;
    done_in  = 1'b0;
    mode_cfg = 2'd0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic pulse_on(input logic [1:0] m);
    mode_cfg = m;
    on_req   = 1'b1;
    tick();
    on_req   = 1'b0;
    mode_cfg = ~m;
  endtask

  task automatic pulse_off();
    off_req = 1'b1;
    tick();
    off_req = 1'b0;
  endtask

  task automatic bring_up(input logic [1:0] m);
    do_reset();
    pulse_on(m);
    pgood_in = 1'b1;
    repeat (7) tick();
    done_in = 1'b1;
    repeat (4) tick();
  endtask

  // R4: boot-mode pins move only while powered and held in reset
  always @(negedge clk) begin
    if (rst_n && (boot_mode !== bm_prev)) chk("R4 mode change window", int'(pwr_en && !por_n), 1);
    bm_prev = boot_mode;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk   = 0;
    n_fail  = 0;
    bm_prev = 2'd0;

    // R1 reset state
    do_reset();
    chk("R1 pwr_en", int'(pwr_en), 0);
    chk("R1 por_n", int'(por_n), 0);
    chk("R1 boot_mode", int'(boot_mode), 0);
    chk("R1 ready", int'(ready), 0);
    chk("R1 fault", int'(fault), 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      pulse_on(VECS[v].mode);
      for (int c = 0; c < OBS_CYC; c++) begin
        if (c == int'(VECS[v].pg_at)) pgood_in = 1'b1;
        if (c == int'(VECS[v].dn_at)) done_in = 1'b1;
        tick();
      end
      chk($sformatf("R5/R6/R7/R11 vec%0d ready", v), int'(ready), int'(VECS[v].ex_ready));
      chk($sformatf("R6/R7/R11 vec%0d fault", v), int'(fault), int'(VECS[v].ex_fault));
      chk($sformatf("R2/R3 vec%0d boot_mode", v), int'(boot_mode), int'(VECS[v].ex_mode));
      chk($sformatf("R5/R7 vec%0d pwr_en", v), int'(pwr_en), int'(VECS[v].ex_ready));
      chk($sformatf("R5/R7 vec%0d por_n", v), int'(por_n), int'(VECS[v].ex_ready));
    end

    // R6 exact short window
    do_reset();
    pulse_on(2'd1);
    repeat (7) tick();
    chk("R6 power still on", int'(pwr_en), 1);
    chk("R6 no fault yet", int'(fault), 0);
    tick();
    chk("R6 fault", int'(fault), 1);
    chk("R6 power off", int'(pwr_en), 0);
    chk("R6 reset held", int'(por_n), 0);

    // R3 cycle timing of mode application and reset release
    do_reset();
    pulse_on(2'd3);
    pgood_in = 1'b1;
    tick();
    tick();
    chk("R3 mode not yet applied", int'(boot_mode), 0);
    tick();
    chk("R3 mode applied", int'(boot_mode), 3);
    chk("R3 reset still low", int'(por_n), 0);
    chk("R3 power on", int'(pwr_en), 1);
    tick();
    chk("R3 reset released", int'(por_n), 1);

    // R2 late mode_cfg ignored, R12 on_req while running ignored
    bring_up(2'd2);
    chk("R5 ready", int'(ready), 1);
    chk("R2 latched mode", int'(boot_mode), 2);
    pulse_on(2'd1);
    repeat (3) tick();
    chk("R12 still ready", int'(ready), 1);
    chk("R12 mode kept", int'(boot_mode), 2);

    // R10 power-off ordering
    pulse_off();
    chk("R10 reset first", int'(por_n), 0);
    chk("R10 power held one cycle", int'(pwr_en), 1);
    tick();
    chk("R10 power dropped", int'(pwr_en), 0);
    chk("R10 no fault", int'(fault), 0);
    chk("R10 not ready", int'(ready), 0);

    // R8 power-good loss, then R9 latch and clear
    bring_up(2'd1);
    pgood_in = 1'b0;
    repeat (3) tick();
    chk("R8 pg fall fault", int'(fault), 1);
    chk("R8 pg fall power", int'(pwr_en), 0);
    chk("R8 pg fall reset", int'(por_n), 0);
    pulse_on(2'd1);
    repeat (3) tick();
    chk("R9 fault held", int'(fault), 1);
    chk("R9 on_req ignored", int'(pwr_en), 0);
    pulse_off();
    chk("R9 fault cleared", int'(fault), 0);
    chk("R9 idle power", int'(pwr_en), 0);

    // R8 done loss
    bring_up(2'd3);
    done_in = 1'b0;
    repeat (3) tick();
    chk("R8 done fall fault", int'(fault), 1);
    chk("R8 done fall power", int'(pwr_en), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule